// File: doc/BRIEF.md
# Strobed Serial Register Slave

This block is the device end of a four-wire serial link made of a host-driven clock, an active-low strobe, a host-to-device data line and a device-to-host data line. Through it a host reaches a small bank of 32-bit registers. These are three read/write configuration words, a switch-input word, a fixed version word, and a reset-control register that drives a timed reset-request output. Every frame is most significant bit first. It has no enclosing select window. Bits stream in on every serial clock rise, and one rise taken while the strobe is low carries the read/write flag and commits the command.

All four link pins are sampled with the block's own system clock. Each pin passes through a short synchronizer, and edges of the serial clock are detected from the synchronized copies. The serial clock must therefore be slow compared with the system clock: each serial clock phase must last at least four system clock cycles. After a read command the addressed word is loaded into an output shifter. Its top bit is shown at once, and the shifter advances on each serial clock fall once the strobe has been released.

Top module: `ssr_slave`

## Requirements
- R1: A write frame is 32 data bits, then 8 address bits, both sent most significant bit first, then one serial clock rise with the strobe low and data-in at 1. That rise commits the write. Addresses 0x00, 0x01 and 0x02 each store all 32 data bits.
- R2: A read frame is 8 address bits, sent most significant bit first, then one serial clock rise with the strobe low and data-in at 0. The value returned is the addressed register as it stands when that command rise is decoded.
- R3: After a read command, bit 31 of the value is on data-out before the first collecting rise that follows the strobe release. Each serial clock fall taken with the strobe high presents the next lower bit, so the host collects 32 bits, most significant first, on 32 rises.
- R4: Data-out is 1 whenever no readout is in progress. This holds after reset, after a write command, and after the fall that follows the 32nd collecting rise.
- R5: Writes to address 0x08, to address 0xFF and to any unmapped address change no register. Reads of an unmapped address return zero.
- R6: A read of 0x08 returns the switch inputs, zero-extended to 32 bits. A read of 0xFF returns the VERSION parameter.
- R7: Writing a word with bit 0 at 1 to address 0x80 raises rst_req for exactly RST_CYCLES system clock cycles. It then clears by itself. Address 0x80 reads back 0 once the pulse has ended. Writing bit 0 at 0 gives no pulse, and a reset write taken while a pulse is running is ignored.
- R8: After rst, data-out is 1 and rst_req is 0. Addresses 0x00, 0x01, 0x02 and 0x80 then read as zero.
- R9: Every serial clock rise with the strobe high shifts data-in into a 40-bit history. Only the last 40 bits before the command rise count, so extra leading bits have no effect on the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the link |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the host, low when idle |
| ser_stb_n | input | 1 | Active-low command strobe, high when idle |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial data to the host, 1 when idle |
| sw_in | input | SW_W | Switch inputs readable at 0x08 |
| rst_req | output | 1 | Timed reset request pulse |

## Verification
The bench puts extra bits in front of a write frame. A design that latched the first 40 bits instead of the last would store a shifted word or hit the wrong address. Readback of alternating and all-ones patterns exposes an output shifter that moves on the strobe-low fall right after the command: such a design would lose bit 31 and return every word shifted left by one. Writes aimed at the version, switch and unmapped addresses, followed by reads of every writable register, catch a decoder that lets a write leak into a neighbouring register. The reset pulse is timed in system clock cycles, and a write of 0 to the reset register is checked to produce no pulse.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int FRAME_W = ADDR_W + DATA_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    localparam addr_t A_MODE    = 8'h00;
    localparam addr_t A_MUX     = 8'h01;
    localparam addr_t A_VIDEO   = 8'h02;
    localparam addr_t A_SWITCH  = 8'h08;
    localparam addr_t A_RESET   = 8'h80;
    localparam addr_t A_VERSION = 8'hFF;

    // decoded command, produced by the strobed rise
    typedef struct packed {
        logic  wr;
        addr_t addr;
        word_t data;
    } cmd_t;

    // writable state of the bank
    typedef struct packed {
        word_t mode;
        word_t mux;
        word_t video;
        logic  rst_pend;
    } regs_t;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    function automatic word_t read_value(addr_t a, regs_t r, word_t sw, word_t ver);
        word_t v;
        unique case (a)
            A_MODE:    v = r.mode;
            A_MUX:     v = r.mux;
            A_VIDEO:   v = r.video;
            A_SWITCH:  v = sw;
            A_RESET:   v = word_t'(r.rst_pend);
            A_VERSION: v = ver;
            default:   v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ssr_pin_sync.sv
module ssr_pin_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/ssr_frame_rx.sv
module ssr_frame_rx
    import ssr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sclk_rise,
    input  logic stb_low,
    input  logic din,
    output logic cmd_valid,
    output cmd_t cmd
);
    logic [FRAME_W-1:0] hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist      <= '0;
            cmd_valid <= 1'b0;
            cmd       <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (sclk_rise) begin
                if (stb_low) begin
                    // strobed rise: data-in is the direction flag
                    cmd_valid <= 1'b1;
                    cmd.wr    <= din;
                    cmd.addr  <= hist[ADDR_W-1:0];
                    cmd.data  <= hist[FRAME_W-1:ADDR_W];
                end else begin
                    hist <= {hist[FRAME_W-2:0], din};
                end
            end
        end
    end
endmodule

// File: rtl/ssr_regbank.sv
module ssr_regbank
    import ssr_pkg::*;
#(
    parameter int RST_CYCLES = 64
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  cmd_valid,
    input  cmd_t  cmd,
    output regs_t regs
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    logic [CNT_W-1:0] pulse_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs      <= '0;
            pulse_cnt <= '0;
        end else begin
            if (regs.rst_pend) begin
                if (pulse_cnt == CNT_W'(RST_CYCLES - 1)) begin
                    regs.rst_pend <= 1'b0;
                    pulse_cnt     <= '0;
                end else begin
                    pulse_cnt <= pulse_cnt + 1'b1;
                end
            end
            if (cmd_valid && cmd.wr) begin
                unique case (cmd.addr)
                    A_MODE:  regs.mode  <= cmd.data;
                    A_MUX:   regs.mux   <= cmd.data;
                    A_VIDEO: regs.video <= cmd.data;
                    A_RESET: begin
                        if (cmd.data[0] && !regs.rst_pend) begin
                            regs.rst_pend <= 1'b1;
                            pulse_cnt     <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ssr_tx.sv
module ssr_tx
    import ssr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cmd_valid,
    input  logic  cmd_wr,
    input  word_t rd_data,
    input  logic  sclk_fall,
    input  logic  stb_low,
    output logic  dout
);
    localparam int BCNT_W = $clog2(DATA_W);

    tx_state_e         state;
    word_t             shreg;
    logic [BCNT_W-1:0] shifts;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TX_IDLE;
            shreg  <= '0;
            shifts <= '0;
        end else if (cmd_valid) begin
            // any new command ends a readout; a read starts a fresh one
            shifts <= '0;
            if (cmd_wr) begin
                state <= TX_IDLE;
            end else begin
                state <= TX_SEND;
                shreg <= rd_data;
            end
        end else if (state == TX_SEND && sclk_fall && !stb_low) begin
            if (shifts == BCNT_W'(DATA_W - 1)) begin
                state <= TX_IDLE;
            end else begin
                shreg  <= {shreg[DATA_W-2:0], 1'b0};
                shifts <= shifts + 1'b1;
            end
        end
    end

    assign dout = (state == TX_SEND) ? shreg[DATA_W-1] : 1'b1;
endmodule

// File: rtl/ssr_slave.sv
module ssr_slave
    import ssr_pkg::*;
#(
    parameter int    SW_W        = 8,
    parameter word_t VERSION     = 32'h0001_0007,
    parameter int    RST_CYCLES  = 64,
    parameter int    SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ser_clk,
    input  logic            ser_stb_n,
    input  logic            ser_din,
    output logic            ser_dout,
    input  logic [SW_W-1:0] sw_in,
    output logic            rst_req
);
    localparam int         PIN_N   = 3;
    localparam logic [2:0] PIN_IDLE = 3'b010; // clk low, strobe high, data low

    logic [PIN_N-1:0] pin_q;
    logic             sclk_d;
    logic             sclk_rise;
    logic             sclk_fall;
    logic             stb_low;
    logic             din_s;
    logic [SW_W-1:0]  sw_m;
    logic [SW_W-1:0]  sw_s;
    logic             cmd_valid;
    cmd_t             cmd;
    regs_t            regs;
    word_t            rd_data;

    ssr_pin_sync #(
        .W       (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_clk, ser_stb_n, ser_din}),
        .q   (pin_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            sw_m   <= '0;
            sw_s   <= '0;
        end else begin
            sclk_d <= pin_q[2];
            sw_m   <= sw_in;
            sw_s   <= sw_m;
        end
    end

    assign sclk_rise = pin_q[2] & ~sclk_d;
    assign sclk_fall = ~pin_q[2] & sclk_d;
    assign stb_low   = ~pin_q[1];
    assign din_s     = pin_q[0];

    ssr_frame_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .sclk_rise (sclk_rise),
        .stb_low   (stb_low),
        .din       (din_s),
        .cmd_valid (cmd_valid),
        .cmd       (cmd)
    );

    ssr_regbank #(
        .RST_CYCLES (RST_CYCLES)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .regs      (regs)
    );

    assign rd_data = read_value(cmd.addr, regs, word_t'(sw_s), VERSION);
    assign rst_req = regs.rst_pend;

    ssr_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_wr    (cmd.wr),
        .rd_data   (rd_data),
        .sclk_fall (sclk_fall),
        .stb_low   (stb_low),
        .dout      (ser_dout)
    );
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker
    import ssr_pkg::*;
#(
    parameter int RST_CYCLES = 64
) (
    input logic  clk,
    input logic  rst,
    input logic  sclk_fall,
    input logic  cmd_valid,
    input cmd_t  cmd,
    input word_t mode_q,
    input logic  dout,
    input logic  rst_req
);
    int unsigned hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)          hi_cnt <= 0;
        else if (rst_req) hi_cnt <= hi_cnt + 1;
        else              hi_cnt <= 0;
    end

    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_req) |-> hi_cnt == RST_CYCLES); // R7

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> $past(cmd_valid && cmd.wr && cmd.addr == A_RESET && cmd.data[0])); // R7

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && cmd.wr && cmd.addr == A_MODE) |=> $stable(mode_q)); // R5

    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(sclk_fall || cmd_valid) |=> $stable(dout)); // R3

    AST_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd.wr) |=> dout); // R4

    AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid); // R2
endmodule

bind ssr_slave ssr_checker #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sclk_fall (sclk_fall),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .mode_q    (regs.mode),
    .dout      (ser_dout),
    .rst_req   (rst_req)
);

// File: tb/sim_ssr_slave.sv
module sim_ssr_slave;
    localparam int          CLK_P  = 10;
    localparam int          H      = 4;
    localparam int          SW_W   = 8;
    localparam logic [31:0] VER    = 32'hA5C3_0917;
    localparam int          RSTC   = 40;
    localparam int          WD_MAX = 190000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ser_clk = 1'b0;
    logic            ser_stb_n = 1'b1;
    logic            ser_din = 1'b0;
    logic            ser_dout;
    logic [SW_W-1:0] sw_in = '0;
    logic            rst_req;

    int vectors = 0;
    int errors  = 0;
    int pulses  = 0;
    int bad_len = 0;
    int hi      = 0;
    int exp_pulses = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    logic [31:0] m_mode = '0, m_mux = '0, m_video = '0;

    always #(CLK_P/2) clk = ~clk;

    ssr_slave #(
        .SW_W       (SW_W),
        .VERSION    (VER),
        .RST_CYCLES (RSTC),
        .SYNC_STAGES(2)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .ser_clk   (ser_clk),
        .ser_stb_n (ser_stb_n),
        .ser_din   (ser_din),
        .ser_dout  (ser_dout),
        .sw_in     (sw_in),
        .rst_req   (rst_req)
    );

    // pulse-length monitor at the port
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_req) hi <= hi + 1;
        else if (hi != 0) begin
            pulses <= pulses + 1;
            if (hi != RSTC) bad_len <= bad_len + 1;
            hi <= 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic waith();
        repeat (H) @(negedge clk);
    endtask

    task automatic sbit(input logic b);
        waith(); ser_din = b;
        waith(); ser_clk = 1'b1;
        waith(); ser_clk = 1'b0;
    endtask

    task automatic strobe_edge(input logic b);
        waith(); ser_din = b; ser_stb_n = 1'b0;
        waith(); ser_clk = 1'b1;
        waith(); ser_clk = 1'b0;
        waith(); ser_stb_n = 1'b1; ser_din = 1'b0;
        waith();
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        for (int i = 31; i >= 0; i--) sbit(d[i]);
        for (int i = 7; i >= 0; i--) sbit(a[i]);
        strobe_edge(1'b1);
        waith();
        chk("R4 idle after write", 32'(ser_dout), 32'd1);
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        d = '0;
        for (int i = 7; i >= 0; i--) sbit(a[i]);
        strobe_edge(1'b0);
        for (int i = 0; i < 32; i++) begin
            ser_clk = 1'b1;
            @(negedge clk);
            d = {d[30:0], ser_dout};
            waith(); ser_clk = 1'b0;
            waith();
        end
        waith();
        chk("R4 idle after readout", 32'(ser_dout), 32'd1);
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00:   return m_mode;
            8'h01:   return m_mux;
            8'h02:   return m_video;
            8'h08:   return 32'(sw_in);
            8'h80:   return 32'd0;
            8'hFF:   return VER;
            default: return 32'd0;
        endcase
    endfunction

    function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
        case (a)
            8'h00:   m_mode  = d;
            8'h01:   m_mux   = d;
            8'h02:   m_video = d;
            default: ;
        endcase
    endfunction

    task automatic wr_model(input logic [7:0] a, input logic [31:0] d);
        do_write(a, d);
        model_write(a, d);
        if (a == 8'h80 && d[0]) exp_pulses++;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a);
        logic [31:0] v;
        do_read(a, v);
        chk(req, v, exp_read(a));
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5EED_1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 dout after reset", 32'(ser_dout), 32'd1);
        chk("R8 rst_req after reset", 32'(rst_req), 32'd0);
        rd_chk("R8 mode reset value", 8'h00);
        rd_chk("R8 mux reset value", 8'h01);
        rd_chk("R8 video reset value", 8'h02);
        rd_chk("R8 reset-ctl reset value", 8'h80);

        rd_chk("R6 version", 8'hFF);
        sw_in = 8'hA6;
        rd_chk("R6 switches pattern A", 8'h08);
        sw_in = 8'h59;
        rd_chk("R6 switches pattern B", 8'h08);

        wr_model(8'h00, 32'hFFFF_FFFF);
        rd_chk("R1 R3 mode all ones", 8'h00);
        wr_model(8'h01, 32'hAAAA_5555);
        rd_chk("R1 R3 mux alternating", 8'h01);
        wr_model(8'h02, 32'h8000_0001);
        rd_chk("R2 R3 video end bits", 8'h02);

        wr_model(8'hFF, 32'h1234_5678);
        wr_model(8'h08, 32'hDEAD_BEEF);
        wr_model(8'h55, 32'h0F0F_0F0F);
        rd_chk("R5 version unchanged", 8'hFF);
        rd_chk("R5 mode unchanged", 8'h00);
        rd_chk("R5 mux unchanged", 8'h01);
        rd_chk("R5 video unchanged", 8'h02);
        rd_chk("R5 unmapped read zero", 8'h55);

        // R9: leading junk bits before a write frame
        for (int i = 0; i < 7; i++) sbit(1'($urandom));
        wr_model(8'h01, 32'h3C96_E1A7);
        rd_chk("R9 last 40 bits used", 8'h01);

        wr_model(8'h80, 32'hFFFF_FFFE);
        chk("R7 no pulse for bit0 zero", 32'(pulses), 32'd0);
        wr_model(8'h80, 32'h0000_0001);
        repeat (RSTC + 10) @(negedge clk);
        chk("R7 one pulse", 32'(pulses), 32'd1);
        chk("R7 pulse length", 32'(bad_len), 32'd0);
        rd_chk("R7 reset-ctl self clears", 8'h80);

        for (int n = 0; n < 70; n++) begin
            logic [7:0]  a;
            logic [31:0] d;
            case ($urandom % 8)
                0: a = 8'h00;
                1: a = 8'h01;
                2: a = 8'h02;
                3: a = 8'h08;
                4: a = 8'h80;
                5: a = 8'hFF;
                default: a = 8'($urandom);
            endcase
            d = $urandom;
            sw_in = SW_W'($urandom);
            if ($urandom % 2) wr_model(a, d);
            else rd_chk("R2 R5 R6 random read", a);
        end
        rd_chk("R1 final mode", 8'h00);
        rd_chk("R1 final mux", 8'h01);
        rd_chk("R1 final video", 8'h02);
        repeat (RSTC + 10) @(negedge clk);
        chk("R7 pulse count", 32'(pulses), 32'(exp_pulses));
        chk("R7 all pulse lengths", 32'(bad_len), 32'd0);
        done = 1'b1;
    end

    initial begin
        wait (done || cyc >= WD_MAX);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: got cycle %0d expected completion", cyc);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule